// File: doc/BRIEF.md
# Indirect Channel Configuration Register Port

This block holds the per-channel setup of a two-channel IDE host controller behind a narrow register window. There are two host-visible locations. One is a byte-wide pointer register and the other is a word-wide data port. The pointer carries a channel-select bit and a three-bit register index. Every read or write of the data port reaches the register that the pointer currently selects in that channel's bank. Each bank has seven registers: two 16-bit base addresses, a general configuration byte, two read-ahead registers that can only be written, and two access-timing bytes.

The pointer also carries bus-level controls: a minimum wait state for posted writes, a master-burst disable bit that can only be written, and a medium decode-timing select. When its auto-increment bit is set, the index advances after every data-port access. A host can then program or dump a whole bank with one pointer write followed by a run of data accesses.

All decoded settings of both banks leave the block on dedicated outputs. A write to the read-ahead configuration with its FIFO-clear bit set produces a single-cycle pulse for that channel instead of storing the bit. Writes take effect at the rising clock edge. Read data is combinational and is valid in the cycle in which the read strobe is high.

Top module: `idx_cfg_port`

## Requirements
- R1: A write to address 1 with be_i[0] set loads the pointer from wdata_i[7:0]. Bit 3 selects the bank (0 primary, 1 secondary) and bits 2..0 select the index. A read of address 1 returns the pointer in rdata_o[7:0], with bit 5 reading as 0 and rdata_o[15:8] zero.
- R2: While pointer bit 7 is set, each data-port access (read or write at address 0) advances pointer bits 2..0 by one, wrapping from 7 to 0, and leaves bits 7..3 unchanged. While bit 7 is clear, data-port accesses leave the pointer unchanged.
- R3: After reset the pointer reads 0x50. wait_st_o, burst_dis_o and devsel_med_o follow pointer bits 6, 5 and 4.
- R4: Index 0 (command base) resets to 0x01F0 on the primary bank and 0x0170 on the secondary bank. Index 4 (control base) resets to 0x03F6 and 0x0376. Both are read/write 16-bit registers and drive cmd_base_o and ctl_base_o, with the bank number selecting the 16-bit slice.
- R5: Index 1 resets to 0x01 and drives gen_cfg_o in full. A read of index 1 returns the stored byte with bit 2 (power save, write-only) forced to 0.
- R6: Index 5 (data-port timing) resets to 0xF5 and index 6 (command-port timing) resets to 0xDE in both banks. They are read/write and drive dat_tim_o and cmd_tim_o.
- R7: Index 2 holds the read-ahead count bits 7..0. Index 3 holds the enable (bit 7), the mode-4 timing bit (bit 4) and the count bits 9..8 (bits 1..0). These drive ra_en_o, mode4_o and the 10-bit ra_cnt_o slice.
- R8: Reads of index 2, 3 or 7 return zero. A write to index 7 has no effect.
- R9: A write to index 3 with be_i[0] set and wdata_i[6] set raises fifo_clr_o for that bank for exactly the next cycle only. The bit is not stored.
- R10: A data-port write changes only the byte lanes whose be_i bit is set. Byte-wide registers occupy lane 0.
- R11: Data-port writes reach only the bank selected by pointer bit 3. The other bank's registers are unchanged.
- R12: rdata_o is zero whenever rd_i is low. Byte-wide registers read back with rdata_o[15:8] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address: 0 data port, 1 pointer |
| be_i | input | 2 | Byte-lane enables for writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| wait_st_o | output | 1 | Posted-write wait state enabled |
| burst_dis_o | output | 1 | Master burst disabled |
| devsel_med_o | output | 1 | Medium decode timing selected |
| cmd_base_o | output | 32 | Command-block base per bank |
| ctl_base_o | output | 32 | Control-block base per bank |
| gen_cfg_o | output | 16 | General configuration byte per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| ra_cnt_o | output | 20 | 10-bit read-ahead count per bank |
| mode4_o | output | 2 | Mode-4 timing enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO-clear pulse per bank |
| dat_tim_o | output | 16 | Data-port timing byte per bank |
| cmd_tim_o | output | 16 | Command-port timing byte per bank |

## Verification
The first sweep walks every index of both banks straight after reset, which separates each default value and each bank from the others. The second sweep writes an arithmetic pattern to all eight indices of one bank through auto-increment, then reads it back. This exposes readback masking, the write-only registers, the index-7 hole and the wrap of the index, and the untouched bank shows any crosstalk between banks. Lane-masked writes, pointer writes with the increment bit clear and a FIFO-clear write then tell a correct design apart from one with wrong lane gating, one that steps the index regardless of the increment bit, or one that stores the pulse.

// File: rtl/icfg_pkg.sv
package icfg_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned RA_W   = 10;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD_BASE = 3'd0,
    IX_GEN      = 3'd1,
    IX_RA_LO    = 3'd2,
    IX_RA_CFG   = 3'd3,
    IX_CTL_BASE = 3'd4,
    IX_DAT_TIM  = 3'd5,
    IX_CMD_TIM  = 3'd6,
    IX_NONE     = 3'd7
  } idx_e;

  localparam logic [7:0] GEN_RST     = 8'h01;
  localparam logic [7:0] GEN_RD_MASK = 8'hFB;
  localparam logic [7:0] DAT_TIM_RST = 8'hF5;
  localparam logic [7:0] CMD_TIM_RST = 8'hDE;

  function automatic logic [DATA_W-1:0] cmd_base_rst(input logic ch);
    return ch ? 16'h0170 : 16'h01F0;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_base_rst(input logic ch);
    return ch ? 16'h0376 : 16'h03F6;
  endfunction
endpackage

// File: rtl/icfg_ptr.sv
module icfg_ptr
  import icfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic             auto_inc_o,
  output logic             wait_st_o,
  output logic             burst_dis_o,
  output logic             devsel_med_o,
  output logic             chan_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_inc_o   <= 1'b0;
      wait_st_o    <= 1'b1;
      burst_dis_o  <= 1'b0;
      devsel_med_o <= 1'b1;
      chan_o       <= 1'b0;
      idx_o        <= '0;
    end else if (ptr_wr_i) begin
      auto_inc_o   <= wdata_i[7];
      wait_st_o    <= wdata_i[6];
      burst_dis_o  <= wdata_i[5];
      devsel_med_o <= wdata_i[4];
      chan_o       <= wdata_i[3];
      idx_o        <= wdata_i[2:0];
    end else if (step_i && auto_inc_o) begin
      idx_o <= idx_o + 3'd1;
    end
  end

  // burst disable is write-only
  assign rdata_o = {auto_inc_o, wait_st_o, 1'b0, devsel_med_o, chan_o, idx_o};

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && auto_inc_o && !ptr_wr_i) |=> (idx_o == $past(idx_o) + 3'd1)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_wr_i && !(step_i && auto_inc_o)) |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/icfg_bank.sv
module icfg_bank
  import icfg_pkg::*;
#(
  parameter logic CH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cmd_base_o,
  output logic [DATA_W-1:0] ctl_base_o,
  output logic [7:0]        gen_cfg_o,
  output logic              ra_en_o,
  output logic [RA_W-1:0]   ra_cnt_o,
  output logic              mode4_o,
  output logic              fifo_clr_o,
  output logic [7:0]        dat_tim_o,
  output logic [7:0]        cmd_tim_o
);
  localparam logic [DATA_W-1:0] CMD_RST = cmd_base_rst(CH);
  localparam logic [DATA_W-1:0] CTL_RST = ctl_base_rst(CH);

  logic       wr_b;
  logic [7:0] ra_lo_q;
  logic [1:0] ra_hi_q;

  assign wr_b = wr_i && be_i[0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_base_o[l*8 +: 8] <= CMD_RST[l*8 +: 8];
        ctl_base_o[l*8 +: 8] <= CTL_RST[l*8 +: 8];
      end else if (wr_i && be_i[l]) begin
        if (idx_i == IX_CMD_BASE) cmd_base_o[l*8 +: 8] <= wdata_i[l*8 +: 8];
        if (idx_i == IX_CTL_BASE) ctl_base_o[l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_cfg_o  <= GEN_RST;
      ra_lo_q    <= '0;
      ra_hi_q    <= '0;
      ra_en_o    <= 1'b0;
      mode4_o    <= 1'b0;
      dat_tim_o  <= DAT_TIM_RST;
      cmd_tim_o  <= CMD_TIM_RST;
      fifo_clr_o <= 1'b0;
    end else begin
      fifo_clr_o <= wr_b && (idx_i == IX_RA_CFG) && wdata_i[6];
      if (wr_b) begin
        unique case (idx_i)
          IX_GEN:     gen_cfg_o <= wdata_i[7:0];
          IX_RA_LO:   ra_lo_q   <= wdata_i[7:0];
          IX_RA_CFG: begin
            ra_en_o <= wdata_i[7];
            mode4_o <= wdata_i[4];
            ra_hi_q <= wdata_i[1:0];
          end
          IX_DAT_TIM: dat_tim_o <= wdata_i[7:0];
          IX_CMD_TIM: cmd_tim_o <= wdata_i[7:0];
          default: ;
        endcase
      end
    end
  end

  assign ra_cnt_o = {ra_hi_q, ra_lo_q};

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IX_CMD_BASE: rdata_o = cmd_base_o;
      IX_CTL_BASE: rdata_o = ctl_base_o;
      IX_GEN:      rdata_o[7:0] = gen_cfg_o & GEN_RD_MASK;
      IX_DAT_TIM:  rdata_o[7:0] = dat_tim_o;
      IX_CMD_TIM:  rdata_o[7:0] = cmd_tim_o;
      default:     rdata_o = '0;
    endcase
  end

  AST_FIFO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> ($past(wr_i) && $past(idx_i) == IX_RA_CFG)); // R9
  AST_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IX_CMD_BASE && !be_i[1]) |=> $stable(cmd_base_o[15:8])); // R10
  AST_IDLE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(cmd_base_o) && $stable(ctl_base_o) && $stable(gen_cfg_o))); // R11
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import icfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES-1:0]         be_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     wait_st_o,
  output logic                     burst_dis_o,
  output logic                     devsel_med_o,
  output logic [NUM_CH*DATA_W-1:0] cmd_base_o,
  output logic [NUM_CH*DATA_W-1:0] ctl_base_o,
  output logic [NUM_CH*8-1:0]      gen_cfg_o,
  output logic [NUM_CH-1:0]        ra_en_o,
  output logic [NUM_CH*RA_W-1:0]   ra_cnt_o,
  output logic [NUM_CH-1:0]        mode4_o,
  output logic [NUM_CH-1:0]        fifo_clr_o,
  output logic [NUM_CH*8-1:0]      dat_tim_o,
  output logic [NUM_CH*8-1:0]      cmd_tim_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(1);

  logic             dat_sel, ptr_sel, data_acc;
  logic             auto_inc, chan;
  logic [IDX_W-1:0] idx;
  logic [7:0]       ptr_rd;
  logic [NUM_CH-1:0] bank_wr;
  logic [DATA_W-1:0] bank_rd [NUM_CH];

  assign dat_sel  = addr_i == A_DATA;
  assign ptr_sel  = addr_i == A_PTR;
  assign data_acc = (wr_i || rd_i) && dat_sel;

  icfg_ptr u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_wr_i     (wr_i && ptr_sel && be_i[0]),
    .wdata_i      (wdata_i[7:0]),
    .step_i       (data_acc),
    .auto_inc_o   (auto_inc),
    .wait_st_o    (wait_st_o),
    .burst_dis_o  (burst_dis_o),
    .devsel_med_o (devsel_med_o),
    .chan_o       (chan),
    .idx_o        (idx),
    .rdata_o      (ptr_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    assign bank_wr[c] = wr_i && dat_sel && (chan == c[0]);

    icfg_bank #(.CH(c[0])) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bank_wr[c]),
      .idx_i      (idx),
      .be_i       (be_i),
      .wdata_i    (wdata_i),
      .rdata_o    (bank_rd[c]),
      .cmd_base_o (cmd_base_o[c*DATA_W +: DATA_W]),
      .ctl_base_o (ctl_base_o[c*DATA_W +: DATA_W]),
      .gen_cfg_o  (gen_cfg_o[c*8 +: 8]),
      .ra_en_o    (ra_en_o[c]),
      .ra_cnt_o   (ra_cnt_o[c*RA_W +: RA_W]),
      .mode4_o    (mode4_o[c]),
      .fifo_clr_o (fifo_clr_o[c]),
      .dat_tim_o  (dat_tim_o[c*8 +: 8]),
      .cmd_tim_o  (cmd_tim_o[c*8 +: 8])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (dat_sel)      rdata_o = bank_rd[chan];
      else if (ptr_sel) rdata_o[7:0] = ptr_rd;
    end
  end

  AST_NO_RD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0)); // R12
  AST_WO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && dat_sel && (idx == IX_RA_LO || idx == IX_RA_CFG || idx == IX_NONE))
      |-> (rdata_o == '0)); // R8
  AST_PTR_RD_B5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ptr_sel) |-> (rdata_o[15:8] == 8'h00 && !rdata_o[5])); // R1
  AST_FIFO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_clr_o)); // R9
endmodule

// File: tb/sim_idx_cfg_port.sv
module sim_idx_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wait_st, burst_dis, devsel_med;
  logic [31:0] cmd_base, ctl_base;
  logic [15:0] gen_cfg, dat_tim, cmd_tim;
  logic [1:0]  ra_en, mode4, fifo_clr;
  logic [19:0] ra_cnt;
  int checks = 0, errors = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  idx_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .wait_st_o(wait_st), .burst_dis_o(burst_dis),
    .devsel_med_o(devsel_med), .cmd_base_o(cmd_base), .ctl_base_o(ctl_base),
    .gen_cfg_o(gen_cfg), .ra_en_o(ra_en), .ra_cnt_o(ra_cnt), .mode4_o(mode4),
    .fifo_clr_o(fifo_clr), .dat_tim_o(dat_tim), .cmd_tim_o(cmd_tim)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [15:0] dflt(input int ch, input int ix);
    case (ix)
      0: return (ch != 0) ? 16'h0170 : 16'h01F0;
      1: return 16'h0001;
      4: return (ch != 0) ? 16'h0376 : 16'h03F6;
      5: return 16'h00F5;
      6: return 16'h00DE;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pat(input int ch, input int ix);
    return 16'(16'h1357 * (ix + 1) + ch * 16'h0F0F);
  endfunction

  function automatic logic [15:0] rd_view(input int ix, input logic [15:0] v);
    case (ix)
      0, 4: return v;
      1: return {8'h00, v[7:0] & 8'hFB};
      5, 6: return {8'h00, v[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle rdata", {16'h0, rdata}, 32'h0);
    bus_rd(2'd1, rv);
    chk("R3 ptr reset", {16'h0, rv}, 32'h50);
    chk("R3 ctl outs", {29'h0, wait_st, burst_dis, devsel_med}, 32'h5);

    // defaults of both banks via auto-increment
    for (int ch = 0; ch < 2; ch++) begin
      bus_wr(2'd1, 16'(8'hD0 | (ch << 3)), 2'b01);
      for (int ix = 0; ix < 8; ix++) begin
        bus_rd(2'd0, rv);
        chk($sformatf("R4 R5 R6 R8 dflt ch%0d ix%0d", ch, ix), {16'h0, rv}, {16'h0, dflt(ch, ix)});
      end
      bus_rd(2'd1, rv);
      chk("R2 ptr wrap after reads", {16'h0, rv}, 32'(8'hD0 | (ch << 3)));
    end
    chk("R4 cmd base outs", cmd_base, 32'h0170_01F0);
    chk("R4 ctl base outs", ctl_base, 32'h0376_03F6);
    chk("R5 gen outs", {16'h0, gen_cfg}, 32'h0101);
    chk("R6 timing outs", {dat_tim, cmd_tim}, 32'hF5F5_DEDE);

    // pattern sweep into bank 0 via auto-increment writes
    bus_wr(2'd1, 16'h00D0, 2'b01);
    for (int ix = 0; ix < 8; ix++) bus_wr(2'd0, pat(0, ix), 2'b11);
    bus_rd(2'd1, rv);
    chk("R2 ptr wrap after writes", {16'h0, rv}, 32'hD0);
    chk("R4 cmd base written", {16'h0, cmd_base[15:0]}, {16'h0, pat(0, 0)});
    chk("R4 ctl base written", {16'h0, ctl_base[15:0]}, {16'h0, pat(0, 4)});
    chk("R5 gen full out", {24'h0, gen_cfg[7:0]}, {24'h0, pat(0, 1)[7:0]});
    chk("R7 ra count", {22'h0, ra_cnt[9:0]}, {22'h0, pat(0, 3)[1:0], pat(0, 2)[7:0]});
    chk("R7 ra en mode4", {30'h0, ra_en[0], mode4[0]}, {30'h0, pat(0, 3)[7], pat(0, 3)[4]});
    chk("R6 timing written", {16'h0, dat_tim[7:0], cmd_tim[7:0]}, {16'h0, pat(0, 5)[7:0], pat(0, 6)[7:0]});
    chk("R11 bank1 untouched", {cmd_base[31:16], ctl_base[31:16]}, 32'h0170_0376);
    chk("R11 bank1 bytes", {8'h0, gen_cfg[15:8], dat_tim[15:8], cmd_tim[15:8]}, 32'h0001_F5DE);
    for (int ix = 0; ix < 8; ix++) begin
      bus_rd(2'd0, rv);
      chk($sformatf("R5 R8 readback ix%0d", ix), {16'h0, rv}, {16'h0, rd_view(ix, pat(0, ix))});
    end

    // pointer field behaviour
    bus_wr(2'd1, 16'h00FF, 2'b01);
    bus_rd(2'd1, rv);
    chk("R1 ptr b5 reads zero", {16'h0, rv}, 32'hDF);
    chk("R3 burst disable out", {29'h0, wait_st, burst_dis, devsel_med}, 32'h7);
    bus_wr(2'd1, 16'h000D, 2'b01);
    bus_rd(2'd0, rv);
    chk("R1 ch1 ix5 select", {16'h0, rv}, 32'hF5);
    bus_rd(2'd0, rv);
    bus_rd(2'd1, rv);
    chk("R2 no step when off", {16'h0, rv}, 32'h0D);
    chk("R3 ctl after clear", {29'h0, wait_st, burst_dis, devsel_med}, 32'h0);
    bus_wr(2'd1, 16'h00AA, 2'b10);
    bus_rd(2'd1, rv);
    chk("R1 ptr needs lane0", {16'h0, rv}, 32'h0D);

    // lane enables
    bus_wr(2'd0, 16'hFF00, 2'b10);
    chk("R10 byte reg lane1 ignored", {24'h0, dat_tim[15:8]}, 32'hF5);
    bus_wr(2'd1, 16'h0008, 2'b01);
    bus_wr(2'd0, 16'hBEEF, 2'b01);
    chk("R10 low lane only", {16'h0, cmd_base[31:16]}, 32'h01EF);
    bus_wr(2'd0, 16'h1234, 2'b10);
    chk("R10 high lane only", {16'h0, cmd_base[31:16]}, 32'h12EF);
    bus_wr(2'd1, 16'h000F, 2'b01);
    bus_wr(2'd0, 16'hFFFF, 2'b11);
    chk("R8 ix7 write no effect", {cmd_base[31:16], ctl_base[31:16]}, 32'h12EF_0376);

    // FIFO clear pulse on bank 0
    bus_wr(2'd1, 16'h0003, 2'b01);
    @(negedge clk);
    wr = 1'b1; addr = 2'd0; wdata = 16'h0040; be = 2'b01;
    @(negedge clk);
    wr = 1'b0; be = '0;
    chk("R9 pulse bank0", {30'h0, fifo_clr}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {30'h0, fifo_clr}, 32'h0);
    bus_rd(2'd0, rv);
    chk("R9 R8 not stored", {16'h0, rv}, 32'h0);
    chk("R7 cfg cleared", {29'h0, ra_en[0], mode4[0], 1'b0}, 32'h0);
    bus_wr(2'd1, 16'h000B, 2'b01);
    bus_wr(2'd0, 16'h4000, 2'b10);
    chk("R9 R10 no pulse lane1", {30'h0, fifo_clr}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule